// File: doc/BRIEF.md
# Serial-bus audio control register bank

This block receives write transfers from a two-wire serial bus controller, the standard I2C protocol, and holds the resulting settings of an audio processor in eight registers. The registers cover source choice, input gain, volume, three tone bands and two speaker attenuators. SCL and SDA are sampled by the system clock through synchronizers. START and STOP are detected from those samples, and acknowledge is driven on SDA as an open-drain pull-down enable.

A transfer starts with START and the device address. A control byte follows, which selects a register and may turn on stepping. Then come any number of data bytes, and STOP ends the transfer. Without stepping, every data byte goes to the same register. With stepping, the register pointer advances after each data byte. The pointer is four bits wide, so it also passes through eight empty slots, and it wraps to zero. All register contents appear on parallel outputs.

Top module: `audio_ctrl_i2c_slave`

## Requirements
- R1: After reset the outputs read: source 2'b10, gain 4'hE, volume 6'h38, bass 4'h7, mid 4'hE, treble 4'hE, right speaker 7'h78, left speaker 7'h78.
- R2: Only the address byte 0x88 (7-bit 0x44, write) is acknowledged. Any other address gets no acknowledge, and the rest of that transfer changes no register.
- R3: START is SDA falling while SCL is high. STOP is SDA rising while SCL is high. STOP ends the transfer and releases SDA.
- R4: The slave pulls SDA low during the ninth clock after each accepted byte: the address, the control byte and every data byte. SDA is released at the next SCL fall.
- R5: Control byte bits 3:0 pick the register: 0 source, 1 gain, 2 volume, 3 bass, 4 mid, 5 treble, 6 right speaker, 7 left speaker. Bits 7:5 have no effect.
- R6: With control bit 4 clear, every data byte until STOP is written to the same register.
- R7: With control bit 4 set, the pointer advances by one after each data byte. Bytes that land on slots 8 to 15 change no register, and the pointer wraps from 15 to 0.
- R8: Data bits above a register's width are dropped. The widths are source 2, gain/bass/mid/treble 4, volume 6, speakers 7 (low bits kept).
- R9: A register changes only once all eight bits of a data byte have been received. A START or STOP inside a byte leaves every register unchanged.
- R10: A repeated START restarts address matching.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 = pull SDA low (acknowledge) |
| src_sel | output | 2 | Source select code |
| in_gain | output | 4 | Input gain code |
| volume | output | 6 | Volume code |
| bass | output | 4 | Bass code |
| mid | output | 4 | Mid band code |
| treble | output | 4 | Treble code |
| spk_r | output | 7 | Right speaker attenuation code |
| spk_l | output | 7 | Left speaker attenuation code |

## Verification
A bit counter or pointer that drifts first shows up at the ports as a missing or misplaced acknowledge on the ninth clock of the byte where the slip happens. It then shows up as a wrong register output one data byte later. A stuck byte-kind state shows as a register being written from the control byte itself, which is visible right after that byte's ninth clock. A missing mid-byte abort shows as a register changing after a transfer that never finished a byte.

// File: rtl/actl_pkg.sv
package actl_pkg;
    localparam int NREG    = 8;
    localparam int PTR_W   = 4;
    localparam int WA_W    = $clog2(NREG);
    localparam int BYTE_W  = 8;
    localparam int CNT_W   = $clog2(BYTE_W + 1);

    typedef enum logic [1:0] {S_IDLE, S_RX, S_ACK, S_SKIP} st_t;
    typedef enum logic [1:0] {K_ADDR, K_CTRL, K_DATA} kind_t;

    typedef struct packed {
        st_t               st;
        kind_t             kind;
        logic [CNT_W-1:0]  cnt;
        logic [BYTE_W-1:0] sh;
        logic [PTR_W-1:0]  ptr;
        logic              inc;
        logic              oe;
        logic              we;
        logic [WA_W-1:0]   wa;
        logic [BYTE_W-1:0] wd;
    } fsm_t;
endpackage

// File: rtl/actl_bus_sampler.sv
module actl_bus_sampler #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_q, sda_q;
    logic scl_p_q, sda_p_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q   <= '1;
            sda_q   <= '1;
            scl_p_q <= 1'b1;
            sda_p_q <= 1'b1;
        end else begin
            scl_q   <= {scl_q[STAGES-2:0], scl_i};
            sda_q   <= {sda_q[STAGES-2:0], sda_i};
            scl_p_q <= scl_q[STAGES-1];
            sda_p_q <= sda_q[STAGES-1];
        end
    end

    assign scl_s     = scl_q[STAGES-1];
    assign sda_s     = sda_q[STAGES-1];
    assign scl_rise  = scl_s & ~scl_p_q;
    assign scl_fall  = ~scl_s & scl_p_q;
    assign start_det = scl_s & scl_p_q & sda_p_q & ~sda_s;
    assign stop_det  = scl_s & scl_p_q & ~sda_p_q & sda_s;
endmodule

// File: rtl/actl_xfer_fsm.sv
module actl_xfer_fsm
    import actl_pkg::*;
#(
    parameter logic [7:0] DEV_ADDR = 8'h88
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sda_s,
    input  logic                scl_rise,
    input  logic                scl_fall,
    input  logic                start_det,
    input  logic                stop_det,
    output logic                sda_oe,
    output logic                wr_en,
    output logic [WA_W-1:0]     wr_addr,
    output logic [BYTE_W-1:0]   wr_data
);
    fsm_t s_d, s_q;

    always_comb begin
        s_d    = s_q;
        s_d.we = 1'b0;
        if (start_det) begin
            s_d.st   = S_RX;
            s_d.kind = K_ADDR;
            s_d.cnt  = '0;
            s_d.oe   = 1'b0;
        end else if (stop_det) begin
            s_d.st = S_IDLE;
            s_d.oe = 1'b0;
        end else begin
            unique case (s_q.st)
                S_RX: begin
                    if (scl_rise && s_q.cnt < CNT_W'(BYTE_W)) begin
                        s_d.sh  = {s_q.sh[BYTE_W-2:0], sda_s};
                        s_d.cnt = s_q.cnt + 1'b1;
                    end else if (scl_fall && s_q.cnt == CNT_W'(BYTE_W)) begin
                        s_d.st = S_ACK;
                        s_d.oe = 1'b1;
                        unique case (s_q.kind)
                            K_ADDR: begin
                                if (s_q.sh == DEV_ADDR) begin
                                    s_d.kind = K_CTRL;
                                end else begin
                                    s_d.st = S_SKIP;
                                    s_d.oe = 1'b0;
                                end
                            end
                            K_CTRL: begin
                                s_d.ptr  = s_q.sh[PTR_W-1:0];
                                s_d.inc  = s_q.sh[PTR_W];
                                s_d.kind = K_DATA;
                            end
                            default: begin
                                s_d.we  = ~s_q.ptr[PTR_W-1];
                                s_d.wa  = s_q.ptr[WA_W-1:0];
                                s_d.wd  = s_q.sh;
                                if (s_q.inc) s_d.ptr = s_q.ptr + 1'b1;
                            end
                        endcase
                    end
                end
                S_ACK: begin
                    if (scl_fall) begin
                        s_d.oe  = 1'b0;
                        s_d.cnt = '0;
                        s_d.st  = S_RX;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: S_IDLE, kind: K_ADDR, cnt: '0, sh: '0, ptr: '0,
                     inc: 1'b0, oe: 1'b0, we: 1'b0, wa: '0, wd: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign sda_oe  = s_q.oe;
    assign wr_en   = s_q.we;
    assign wr_addr = s_q.wa;
    assign wr_data = s_q.wd;
endmodule

// File: rtl/actl_reg_bank.sv
module actl_reg_bank
    import actl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WA_W-1:0]   wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [1:0]        src_sel,
    output logic [3:0]        in_gain,
    output logic [5:0]        volume,
    output logic [3:0]        bass,
    output logic [3:0]        mid,
    output logic [3:0]        treble,
    output logic [6:0]        spk_r,
    output logic [6:0]        spk_l
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_sel <= 2'b10;
            in_gain <= 4'b1110;
            volume  <= 6'b111000;
            bass    <= 4'b0111;
            mid     <= 4'b1110;
            treble  <= 4'b1110;
            spk_r   <= 7'b1111000;
            spk_l   <= 7'b1111000;
        end else if (wr_en) begin
            unique case (wr_addr)
                3'd0: src_sel <= wr_data[1:0];
                3'd1: in_gain <= wr_data[3:0];
                3'd2: volume  <= wr_data[5:0];
                3'd3: bass    <= wr_data[3:0];
                3'd4: mid     <= wr_data[3:0];
                3'd5: treble  <= wr_data[3:0];
                3'd6: spk_r   <= wr_data[6:0];
                default: spk_l <= wr_data[6:0];
            endcase
        end
    end
endmodule

// File: rtl/audio_ctrl_i2c_slave.sv
module audio_ctrl_i2c_slave
    import actl_pkg::*;
#(
    parameter logic [7:0] DEV_ADDR    = 8'h88,
    parameter int         SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    output logic [1:0] src_sel,
    output logic [3:0] in_gain,
    output logic [5:0] volume,
    output logic [3:0] bass,
    output logic [3:0] mid,
    output logic [3:0] treble,
    output logic [6:0] spk_r,
    output logic [6:0] spk_l
);
    logic scl_sync, sda_sync, scl_rise, scl_fall, start_det, stop_det;
    logic              wr_en;
    logic [WA_W-1:0]   wr_addr;
    logic [BYTE_W-1:0] wr_data;

    actl_bus_sampler #(.STAGES(SYNC_STAGES)) u_smp (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_sync), .sda_s(sda_sync), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det)
    );

    actl_xfer_fsm #(.DEV_ADDR(DEV_ADDR)) u_fsm (
        .clk(clk), .rst_n(rst_n), .sda_s(sda_sync), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
        .sda_oe(sda_oe), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    actl_reg_bank u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .src_sel(src_sel), .in_gain(in_gain),
        .volume(volume), .bass(bass), .mid(mid), .treble(treble),
        .spk_r(spk_r), .spk_l(spk_l)
    );
endmodule

// File: rtl/actl_checker.sv
module actl_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        sda_oe,
    input logic        scl_sync,
    input logic        scl_fall,
    input logic        start_det,
    input logic        stop_det,
    input logic        wr_en,
    input logic [37:0] bank
);
    // R4: acknowledge drive only moves while the sampled clock is low
    p_oe_scl_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_sync);

    // R10: a START always leaves SDA released for the new address byte
    p_start_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> !sda_oe);

    // R3: a STOP releases SDA and triggers no write
    p_stop_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (!sda_oe && !wr_en));

    // R9: registers hold unless a completed byte is being written
    p_bank_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(bank));

    // R9: a write follows the clock fall that ends the eighth bit
    p_wr_after_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $past(scl_fall));
endmodule

bind audio_ctrl_i2c_slave actl_checker u_chk (
    .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .scl_sync(scl_sync),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .wr_en(wr_en),
    .bank({src_sel, in_gain, volume, bass, mid, treble, spk_r, spk_l})
);

// File: tb/sim_audio_ctrl_i2c_slave.sv
module sim_audio_ctrl_i2c_slave;
    localparam int H = 10;
    logic clk = 1'b0, rst_n = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic sda_oe;
    logic [1:0] src_sel;
    logic [3:0] in_gain, bass, mid, treble;
    logic [5:0] volume;
    logic [6:0] spk_r, spk_l;
    wire  sda_line = sda_m & ~sda_oe;
    int checks = 0, errors = 0;

    always #5 clk = ~clk;

    audio_ctrl_i2c_slave u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .sda_oe(sda_oe), .src_sel(src_sel), .in_gain(in_gain),
        .volume(volume), .bass(bass), .mid(mid), .treble(treble),
        .spk_r(spk_r), .spk_l(spk_l)
    );

    // entry: {control byte, data byte, register index, expected value}
    localparam logic [26:0] VEC [8] = '{
        {8'h00, 8'hFF, 3'd0, 8'h03},
        {8'h01, 8'hC5, 3'd1, 8'h05},
        {8'h02, 8'hEA, 3'd2, 8'h2A},
        {8'h03, 8'h03, 3'd3, 8'h03},
        {8'hE4, 8'h0B, 3'd4, 8'h0B},
        {8'h05, 8'h9A, 3'd5, 8'h0A},
        {8'h06, 8'hD5, 3'd6, 8'h55},
        {8'h07, 8'hFF, 3'd7, 8'h7F}
    };

    function automatic logic [7:0] reg_of(int i);
        case (i)
            0: return {6'd0, src_sel};
            1: return {4'd0, in_gain};
            2: return {2'd0, volume};
            3: return {4'd0, bass};
            4: return {4'd0, mid};
            5: return {4'd0, treble};
            6: return {1'b0, spk_r};
            default: return {1'b0, spk_l};
        endcase
    endfunction

    task automatic wclk(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wclk(H);
        scl_m = 1'b1; wclk(H);
        sda_m = 1'b0; wclk(H);
        scl_m = 1'b0; wclk(H);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wclk(H);
        scl_m = 1'b1; wclk(H);
        sda_m = 1'b1; wclk(H);
    endtask

    task automatic send(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wclk(H);
            scl_m = 1'b1; wclk(H);
            scl_m = 1'b0;
        end
        sda_m = 1'b1; wclk(H);
        scl_m = 1'b1; wclk(H / 2);
        ack = ~sda_line;
        wclk(H / 2);
        scl_m = 1'b0; wclk(1);
    endtask

    task automatic write1(input logic [7:0] ctrl, input logic [7:0] d);
        logic a;
        bus_start();
        send(8'h88, a); chk("R4 addr ack", {7'd0, a}, 8'd1);
        send(ctrl, a);  chk("R4 ctrl ack", {7'd0, a}, 8'd1);
        send(d, a);     chk("R4 data ack", {7'd0, a}, 8'd1);
        bus_stop();
    endtask

    initial begin
        logic a;
        logic [7:0] snap [8];
        wclk(5);
        rst_n = 1'b1;
        wclk(5);
        // R1 reset values
        chk("R1 src",    reg_of(0), 8'h02);
        chk("R1 gain",   reg_of(1), 8'h0E);
        chk("R1 volume", reg_of(2), 8'h38);
        chk("R1 bass",   reg_of(3), 8'h07);
        chk("R1 mid",    reg_of(4), 8'h0E);
        chk("R1 treble", reg_of(5), 8'h0E);
        chk("R1 spk_r",  reg_of(6), 8'h78);
        chk("R1 spk_l",  reg_of(7), 8'h78);
        chk("R1 sda released", {7'd0, sda_oe}, 8'd0);

        // R5 R8 table walk
        for (int v = 0; v < 8; v++) begin
            write1(VEC[v][26:19], VEC[v][18:11]);
            chk("R5 R8 register value", reg_of(int'(VEC[v][10:8])), VEC[v][7:0]);
        end

        // R2 wrong address: no ack, later bytes ignored
        bus_start();
        send(8'h8A, a); chk("R2 nack", {7'd0, a}, 8'd0);
        send(8'h03, a); chk("R2 no ack after nack", {7'd0, a}, 8'd0);
        send(8'h0F, a);
        bus_stop();
        chk("R2 bass untouched", reg_of(3), 8'h03);

        // R6 non-stepping: all bytes to one register
        bus_start();
        send(8'h88, a);
        send(8'h01, a);
        send(8'h04, a); chk("R6 first byte", reg_of(1), 8'h04);
        send(8'h09, a); chk("R6 second byte same reg", reg_of(1), 8'h09);
        send(8'h0C, a); chk("R4 ack on third data", {7'd0, a}, 8'd1);
        bus_stop();
        chk("R6 last byte", reg_of(1), 8'h0C);
        chk("R6 neighbour untouched", reg_of(2), 8'h2A);

        // R7 stepping from 6 through empty slots, wrap to 0
        for (int i = 0; i < 8; i++) snap[i] = reg_of(i);
        bus_start();
        send(8'h88, a);
        send(8'h16, a);
        send(8'h11, a);
        send(8'h22, a);
        for (int i = 0; i < 8; i++) begin
            send(8'h0D, a);
            chk("R7 ack in empty slot", {7'd0, a}, 8'd1);
        end
        send(8'h01, a);
        send(8'h00, a);
        bus_stop();
        chk("R7 slot 6", reg_of(6), 8'h11);
        chk("R7 slot 7", reg_of(7), 8'h22);
        chk("R7 wrap to 0", reg_of(0), 8'h01);
        chk("R7 wrap to 1", reg_of(1), 8'h00);
        for (int i = 2; i < 6; i++) chk("R7 empty slots discarded", reg_of(i), snap[i]);

        // R9 STOP inside a data byte
        bus_start();
        send(8'h88, a);
        send(8'h05, a);
        for (int i = 7; i >= 4; i--) begin
            sda_m = 1'b0; wclk(H);
            scl_m = 1'b1; wclk(H);
            scl_m = 1'b0;
        end
        bus_stop();
        chk("R9 stop mid-byte", reg_of(5), 8'h0A);

        // R9 R10 repeated START mid-byte, then wrong then right address
        bus_start();
        send(8'h88, a);
        send(8'h03, a);
        for (int i = 0; i < 3; i++) begin
            sda_m = 1'b1; wclk(H);
            scl_m = 1'b1; wclk(H);
            scl_m = 1'b0;
        end
        bus_start();
        chk("R9 start mid-byte", reg_of(3), 8'h03);
        send(8'h03, a); chk("R10 data byte taken as address", {7'd0, a}, 8'd0);
        bus_start();
        send(8'h88, a); chk("R10 readdressed", {7'd0, a}, 8'd1);
        send(8'h03, a);
        send(8'h0D, a);
        bus_stop();
        chk("R10 write after restart", reg_of(3), 8'h0D);
        chk("R3 released after stop", {7'd0, sda_oe}, 8'd0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual timeout expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule